// File: doc/BRIEF.md
# Predicated Element Step Sequencer

This block drives the element loop of a vector operation that is governed by a single predicate mask. A start pulse captures a vector length, the mask and the zeroing settings for the source side and for the destination side. The block then presents one step at a time: a source element index, a destination element index and, for each side, a flag that says whether that element is active or is to be zeroed. The consumer takes a step by raising `advance`. The block does not perform the element operation itself. It only produces the index sequence.

Each side follows the same mask, but each applies its own zeroing setting. A side that skips visits only the elements whose mask bit is set. A side that zeroes visits every element below the vector length, and the masked-out ones are flagged as zeroed. Both indices move on every step, so they can drift apart when the two settings differ. The loop ends as soon as either side runs out of elements. At that point a one-cycle `done` pulse is raised.

Top module: `elem_step_seq`

## Requirements
- R1: A `start` pulse taken while idle captures the configuration, and the first step appears with `step_valid`=1 in the cycle after. After reset, `step_valid` and `done` are 0. While `step_valid`=1 and `advance`=0, the step and both indices hold unchanged.
- R2: Mask bit i (bit 0 is the LSB) belongs to element i. Bits at or above `vl` have no effect, and any `vl` above `MAX_VL` acts as `MAX_VL`.
- R3: A side whose zeroing setting is 0 visits, in ascending order, only the elements below `vl` whose mask bit is 1.
- R4: A side whose zeroing setting is 1 visits every element from 0 to `vl`-1 in ascending order.
- R5: Each `advance` taken while `step_valid`=1 moves both indices together to their next element. Each index strictly increases.
- R6: `src_active` and `dst_active` equal the mask bit of the element being presented: 1 means active, 0 means zeroed.
- R7: When the two effective zeroing settings are equal, `src_idx` equals `dst_idx` on every step.
- R8: When `comb_zero_en`=1, both sides take their zeroing setting from `comb_zero`, and `src_zero` and `dst_zero` are ignored.
- R9: When `mask_en`=0, the mask is treated as all ones.
- R10: The loop ends when either side has no further element. `done` is then 1 for exactly one cycle, with `step_valid`=0.
- R11: If `vl` is 0, or if a skipping side has no set mask bit below `vl`, then `done` pulses in the cycle after `start` and no step is presented.
- R12: A `start` raised while a loop is running is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a loop (taken only while idle) |
| vl | input | VLW | Vector length |
| mask | input | MAX_VL | Predicate mask, bit i for element i |
| mask_en | input | 1 | 1: use `mask`; 0: treat the mask as all ones |
| src_zero | input | 1 | Source side zeroes masked elements instead of skipping them |
| dst_zero | input | 1 | Destination side zeroes masked elements instead of skipping them |
| comb_zero_en | input | 1 | Apply `comb_zero` to both sides |
| comb_zero | input | 1 | Combined zeroing setting |
| advance | input | 1 | Consume the presented step |
| step_valid | output | 1 | A step is presented |
| src_idx | output | IW | Source element index |
| dst_idx | output | IW | Destination element index |
| src_active | output | 1 | Source element active (1) or zeroed (0) |
| dst_active | output | 1 | Destination element active (1) or zeroed (0) |
| done | output | 1 | One-cycle end-of-loop pulse |

## Verification
Several properties are checked on every cycle by assertions. The presented step holds while stalled. Both indices rise on each advance. Indices stay below the captured length. The indices are equal when the zeroing settings match. `done` is a single-cycle pulse that never coincides with a step. The exact index pairs that come from a given mask and zeroing setting can only be shown by the bench scenarios. The same holds for the active/zeroed flags, the combined-flag override, the all-ones default, the empty-loop cases and the start that is ignored while busy. The bench compares those scenarios against its own list-based model.

// File: rtl/elem_step_pkg.sv
package elem_step_pkg;
    localparam int NUM_SIDES = 2;
    typedef enum int {
        SIDE_SRC = 0,
        SIDE_DST = 1
    } side_e;
endpackage

// File: rtl/elem_elig.sv
module elem_elig #(
    parameter int MAX_VL = 16,
    localparam int VLW   = $clog2(MAX_VL + 1)
) (
    input  logic [VLW-1:0]    vl,
    input  logic [MAX_VL-1:0] mask,
    input  logic              zero,
    output logic [MAX_VL-1:0] elig
);
    // An element is eligible when it lies below the length and either the
    // side zeroes (visits everything) or its mask bit is set.
    for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
        assign elig[i] = (VLW'(i) < vl) && (zero || mask[i]);
    end
endmodule

// File: rtl/elem_scan.sv
module elem_scan #(
    parameter int MAX_VL = 16,
    localparam int IW    = $clog2(MAX_VL)
) (
    input  logic [MAX_VL-1:0] elig,
    input  logic [IW-1:0]     base,
    input  logic              from_zero,
    output logic              found,
    output logic [IW-1:0]     idx
);
    // Lowest eligible element strictly above base, or from 0 when from_zero.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = 0; j < MAX_VL; j++) begin
            if (!found && elig[j] && (from_zero || j > int'(base))) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq #(
    parameter int MAX_VL = 16,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IW    = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VLW-1:0]    vl,
    input  logic [MAX_VL-1:0] mask,
    input  logic              mask_en,
    input  logic              src_zero,
    input  logic              dst_zero,
    input  logic              comb_zero_en,
    input  logic              comb_zero,
    input  logic              advance,
    output logic              step_valid,
    output logic [IW-1:0]     src_idx,
    output logic [IW-1:0]     dst_idx,
    output logic              src_active,
    output logic              dst_active,
    output logic              done
);
    import elem_step_pkg::*;

    typedef struct packed {
        logic                          busy;
        logic                          done;
        logic [VLW-1:0]                vl;
        logic [MAX_VL-1:0]             mask;
        logic [NUM_SIDES-1:0]          zero;
        logic [NUM_SIDES-1:0][IW-1:0]  idx;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic                          take_start;
    logic [MAX_VL-1:0]             eff_mask;
    logic [NUM_SIDES-1:0]          eff_zero;
    logic [VLW-1:0]                sel_vl;
    logic [MAX_VL-1:0]             sel_mask;
    logic [NUM_SIDES-1:0]          sel_zero;
    logic [NUM_SIDES-1:0]          side_found;
    logic [NUM_SIDES-1:0][IW-1:0]  side_next;
    logic [VLW-1:0]                vl_cap;
    logic [NUM_SIDES-1:0]          zero_cap;

    assign take_start = start && !state_q.busy;
    assign eff_mask   = mask_en ? mask : '1;
    assign eff_zero[SIDE_SRC] = comb_zero_en ? comb_zero : src_zero;
    assign eff_zero[SIDE_DST] = comb_zero_en ? comb_zero : dst_zero;

    // Configuration seen by the scanners: fresh inputs on start, captured otherwise.
    assign sel_vl   = take_start ? vl       : state_q.vl;
    assign sel_mask = take_start ? eff_mask : state_q.mask;
    assign sel_zero = take_start ? eff_zero : state_q.zero;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        logic [MAX_VL-1:0] elig;

        elem_elig #(.MAX_VL(MAX_VL)) u_elig (
            .vl   (sel_vl),
            .mask (sel_mask),
            .zero (sel_zero[s]),
            .elig (elig)
        );

        elem_scan #(.MAX_VL(MAX_VL)) u_scan (
            .elig      (elig),
            .base      (state_q.idx[s]),
            .from_zero (take_start),
            .found     (side_found[s]),
            .idx       (side_next[s])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (take_start) begin
            state_d.vl   = vl;
            state_d.mask = eff_mask;
            state_d.zero = eff_zero;
            if (&side_found) begin
                state_d.busy = 1'b1;
                state_d.idx  = side_next;
            end else begin
                state_d.done = 1'b1;
            end
        end else if (state_q.busy && advance) begin
            if (&side_found) begin
                state_d.idx = side_next;
            end else begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign step_valid = state_q.busy;
    assign done       = state_q.done;
    assign src_idx    = state_q.idx[SIDE_SRC];
    assign dst_idx    = state_q.idx[SIDE_DST];
    assign src_active = state_q.mask[state_q.idx[SIDE_SRC]];
    assign dst_active = state_q.mask[state_q.idx[SIDE_DST]];
    assign vl_cap     = state_q.vl;
    assign zero_cap   = state_q.zero;
endmodule

// File: rtl/elem_step_seq_chk.sv
module elem_step_seq_chk #(
    parameter int MAX_VL = 16,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IW    = $clog2(MAX_VL)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           advance,
    input logic           step_valid,
    input logic           done,
    input logic [IW-1:0]  src_idx,
    input logic [IW-1:0]  dst_idx,
    input logic [VLW-1:0] vl_cap,
    input logic [1:0]     zero_cap
);
    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !advance) |=> (step_valid && $stable(src_idx) && $stable(dst_idx)));

    // R5
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && advance) |=> (!step_valid ||
            (src_idx > $past(src_idx) && dst_idx > $past(dst_idx))));

    // R2
    idx_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> ({1'b0, src_idx} < vl_cap && {1'b0, dst_idx} < vl_cap));

    // R7
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && zero_cap[0] == zero_cap[1]) |-> (src_idx == dst_idx));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && step_valid));
endmodule

bind elem_step_seq elem_step_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .step_valid (step_valid),
    .done       (done),
    .src_idx    (src_idx),
    .dst_idx    (dst_idx),
    .vl_cap     (vl_cap),
    .zero_cap   (zero_cap)
);

// File: tb/elem_step_seq_tb.sv
module elem_step_seq_tb;
    localparam int MAX_VL = 16;
    localparam int VLW    = $clog2(MAX_VL + 1);
    localparam int IW     = $clog2(MAX_VL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VLW-1:0]    vl = '0;
    logic [MAX_VL-1:0] mask = '0;
    logic              mask_en = 1'b0;
    logic              src_zero = 1'b0;
    logic              dst_zero = 1'b0;
    logic              comb_zero_en = 1'b0;
    logic              comb_zero = 1'b0;
    logic              advance = 1'b0;
    logic              step_valid, src_active, dst_active, done;
    logic [IW-1:0]     src_idx, dst_idx;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    elem_step_seq #(.MAX_VL(MAX_VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask(mask),
        .mask_en(mask_en), .src_zero(src_zero), .dst_zero(dst_zero),
        .comb_zero_en(comb_zero_en), .comb_zero(comb_zero), .advance(advance),
        .step_valid(step_valid), .src_idx(src_idx), .dst_idx(dst_idx),
        .src_active(src_active), .dst_active(dst_active), .done(done)
    );

    // Observed word: {step_valid, done, src_idx, dst_idx, src_active, dst_active}
    task automatic expect_out(input string req, input logic sv, input logic dn,
                              input int s, input int d, input logic sa, input logic da);
        logic [11:0] got, exp;
        got = {step_valid, done, src_idx, dst_idx, src_active, dst_active};
        exp = {sv, dn, 4'(s), 4'(d), sa, da};
        if (!sv) begin
            got[9:0] = '0;
            exp[9:0] = '0;
        end
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic run_case(input string req, input int len, input logic [15:0] m,
                            input bit men, input bit zs, input bit zd,
                            input bit ce, input bit cz, input bit stall, input bit poke);
        logic [15:0] eff;
        bit ezs, ezd;
        int sq[$];
        int dq[$];
        int n;
        eff = men ? m : 16'hFFFF;
        ezs = ce ? cz : zs;
        ezd = ce ? cz : zd;
        for (int i = 0; i < len && i < MAX_VL; i++) begin
            if (ezs || eff[i]) sq.push_back(i);
            if (ezd || eff[i]) dq.push_back(i);
        end
        n = (sq.size() < dq.size()) ? sq.size() : dq.size();
        @(negedge clk);
        vl = VLW'(len); mask = m; mask_en = men; src_zero = zs; dst_zero = zd;
        comb_zero_en = ce; comb_zero = cz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            expect_out(req, 1'b1, 1'b0, sq[k], dq[k], eff[sq[k]], eff[dq[k]]);
            if (stall && k == 0) begin
                @(negedge clk);
                expect_out("R1 stall", 1'b1, 1'b0, sq[k], dq[k], eff[sq[k]], eff[dq[k]]);
            end
            if (poke && k == 0) begin
                vl = '0; mask = '0; src_zero = ~zs; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                expect_out("R12 busy start", 1'b1, 1'b0, sq[k], dq[k], eff[sq[k]], eff[dq[k]]);
            end
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
        end
        expect_out(n == 0 ? "R11 empty loop" : "R10 end", 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R10 done pulse", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 idle", 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        // R3 R4 R6: source zeroes, destination skips -> (0,0),(1,2),(2,3)
        run_case("R4 src zero dst skip", 4, 16'b1101, 1, 1, 0, 0, 0, 1, 0);
        // R3 R7: both skip -> (0,0),(2,2),(3,3)
        run_case("R3 both skip", 4, 16'b1101, 1, 0, 0, 0, 0, 0, 0);
        // R5: source skips, destination zeroes -> (0,0),(2,1),(3,2)
        run_case("R5 src skip dst zero", 4, 16'b1101, 1, 0, 1, 0, 0, 0, 0);
        // R7 R6: both zero, lockstep with zeroed flags
        run_case("R7 both zero", 4, 16'b1101, 1, 1, 1, 0, 0, 0, 0);
        // R9: mask ignored when not enabled
        run_case("R9 no predicate", 5, 16'h0000, 0, 0, 0, 0, 0, 0, 0);
        // R11: zero length
        run_case("R11 vl zero", 0, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0);
        // R11: skipping side with empty mask
        run_case("R11 empty mask", 4, 16'h0000, 1, 1, 0, 0, 0, 0, 0);
        // R8: combined flag overrides separate ones
        run_case("R8 combined skip", 4, 16'b1101, 1, 1, 0, 1, 0, 0, 0);
        run_case("R8 combined zero", 4, 16'b0110, 1, 0, 0, 1, 1, 0, 0);
        // R2: mask bits at and above vl have no effect
        run_case("R2 bits above vl", 3, 16'hFFFA, 1, 0, 0, 0, 0, 0, 0);
        run_case("R2 full length", 16, 16'hA5A5, 1, 0, 1, 0, 0, 1, 0);
        // R12: start during a loop is ignored
        run_case("R12 loop", 6, 16'b101101, 1, 0, 1, 0, 0, 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule